// File: doc/BRIEF.md
# Buffered Flash Page-Program Engine

This block drives the write side of a serial NOR flash interface. It sends one program transaction at a time on a single data wire: an opcode byte, a three- or four-byte address, and then the data. The data is either a full page taken from an internal write buffer, or one byte taken from a single-byte data register. Erase, status polling and write-enable sequencing are handled elsewhere.

Software first requests buffer mode and polls the enable read-back until it shows the mode has switched. It then pushes the page as 32-bit words. Each word holds four consecutive bytes, with the lowest-addressed byte in bits 7:0. Next it sets the opcode, address and address-length flag, and writes the start bit. The start bit reads back as busy until the last bit has been shifted out. If buffer mode is on but the buffer is not full, the start request is refused and an underfill flag is raised.

The serial clock idles low. Data changes only while the clock is low and is held stable while it is high. The chip select is held low for the whole frame.

Top module: `nor_page_writer`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, wr_busy is 0, buf_en_ack is 0 and underfill_err is 0.
- R2: buf_en_ack takes the value of buf_en_req one clock after the request, but only while no transfer is running. A change requested during a transfer takes effect after the transfer ends.
- R3: Each accepted pd_word supplies four page bytes in little-endian order. Bits 7:0 are page byte 4k and bits 31:24 are page byte 4k+3, where k is the word's push order counted from 0.
- R4: Once the buffer holds PAGE_BYTES/4 words, further pushes are ignored and do not change the page that is sent.
- R5: The word count returns to zero when buffer mode is switched on, so the next page is filled again from byte 0.
- R6: A frame starts with tx_opcode, followed by the address most significant byte first. When addr_4byte is 0, the address is the 3 bytes flash_addr[23:0].
- R7: When addr_4byte is 1, the address is the 4 bytes flash_addr[31:0], sent most significant byte first.
- R8: With buffer mode on and a full buffer, the frame carries exactly PAGE_BYTES data bytes in ascending page order, and chip select rises right after the last one.
- R9: With buffer mode off, the frame carries exactly one data byte, single_byte.
- R10: wr_start begins a frame and wr_busy stays 1 until the frame ends. A wr_start seen while busy is ignored and starts no further frame.
- R11: wr_start with buffer mode on and fewer than PAGE_BYTES/4 words loaded sets underfill_err and sends nothing. The next accepted start clears the flag.
- R12: Serial timing is clock mode 0 on one wire. Each byte is sent most significant bit first, spi_mosi is stable while spi_sck is high, and spi_sck is low whenever no byte is shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_en_req | input | 1 | Requested buffer-mode setting |
| buf_en_ack | output | 1 | Buffer mode actually in effect |
| pd_valid | input | 1 | Push one word into the write buffer |
| pd_word | input | WORD_W | Page data word, little-endian bytes |
| tx_opcode | input | 8 | Program opcode |
| flash_addr | input | 32 | Flash byte address |
| addr_4byte | input | 1 | Send a four-byte address |
| single_byte | input | 8 | Data byte for the unbuffered program |
| wr_start | input | 1 | Start-bit write pulse |
| wr_busy | output | 1 | Start bit read-back; high while a frame runs |
| underfill_err | output | 1 | Start refused because the buffer was not full |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |

## Verification
The bench checks the byte lanes within each pushed word against the order of the bytes on the wire. A design with the lanes reversed would send each group of four bytes backwards. It pushes a thirty-third word and expects it never to appear, which catches a counter that wraps around and overwrites the first word. It drops the mode request in the middle of a frame and requires the read-back to wait until the frame ends, and it issues a second start while busy, which a faulty design would turn into a duplicate frame. It also loads only part of the buffer before a start. It expects a refusal with the flag set and the chip select left high, and a later full start must clear the flag and send data beginning again at page byte 0.

// File: rtl/npw_pkg.sv
package npw_pkg;
   localparam int NPW_ADDR_W = 32;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADDR,
      ST_DATA
   } npw_state_e;

   typedef struct packed {
      logic [7:0]            opcode;
      logic [NPW_ADDR_W-1:0] addr;
      logic                  four;
      logic                  buffered;
      logic [7:0]            single;
   } npw_job_t;
endpackage

// File: rtl/npw_word_buf.sv
module npw_word_buf #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 32,
   localparam int BPW   = WORD_W / 8,
   localparam int LANEB = (BPW > 1) ? $clog2(BPW) : 1,
   localparam int IDXW  = $clog2(DEPTH * BPW),
   localparam int WIDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [WORD_W-1:0] wdata,
   input  logic [IDXW-1:0]   rd_idx,
   output logic [7:0]        rd_byte,
   output logic              full
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic [CW-1:0]     count;
   logic [WIDXW-1:0]  rd_word;
   logic [LANEB-1:0]  rd_lane;

   assign full = (count == CW'(DEPTH));

   generate
      if (BPW == 1) begin : g_one_lane
         assign rd_word = WIDXW'(rd_idx);
         assign rd_lane = '0;
      end else begin : g_lanes
         assign rd_word = WIDXW'(rd_idx >> LANEB);
         assign rd_lane = rd_idx[LANEB-1:0];
      end
   endgenerate

   assign rd_byte = mem[rd_word][{rd_lane, 3'b000} +: 8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (push && !full) begin
         count <= count + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!clr && push && !full) begin
         mem[WIDXW'(count)] <= wdata;
      end
   end

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   p_full_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !clr) |=> full);
   p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));
endmodule

// File: rtl/npw_bit_shifter.sv
module npw_bit_shifter #(
   parameter int SCK_HALF = 2,
   localparam int DW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] din,
   output logic       idle,
   output logic       done,
   output logic       sck,
   output logic       mosi
);
   logic [7:0] sr;
   logic [3:0] bits;
   logic       active;
   logic       tick;

   generate
      if (SCK_HALF == 1) begin : g_fast
         assign tick = active;
      end else begin : g_div
         logic [DW-1:0] div;
         assign tick = active && (div == DW'(SCK_HALF - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             div <= '0;
            else if (load || tick)  div <= '0;
            else if (active)        div <= div + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr     <= '0;
         bits   <= '0;
         active <= 1'b0;
         sck    <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            sr     <= din;
            bits   <= 4'd8;
            active <= 1'b1;
            sck    <= 1'b0;
         end else if (tick) begin
            if (!sck) begin
               sck <= 1'b1;
            end else begin
               sck  <= 1'b0;
               sr   <= {sr[6:0], 1'b0};
               bits <= bits - 1'b1;
               if (bits == 4'd1) begin
                  active <= 1'b0;
                  done   <= 1'b1;
               end
            end
         end
      end
   end

   assign idle = !active;
   assign mosi = sr[7];

   p_load_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !active);
   p_mosi_stable_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));
   p_sck_low_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !sck);
endmodule

// File: rtl/npw_sequencer.sv
module npw_sequencer
   import npw_pkg::*;
#(
   parameter int PAGE_BYTES = 128,
   localparam int IDXW = $clog2(PAGE_BYTES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  npw_job_t        job,
   input  logic            buf_full,
   input  logic [7:0]      buf_byte,
   output logic [IDXW-1:0] buf_idx,
   input  logic            sh_idle,
   input  logic            sh_done,
   output logic            sh_load,
   output logic [7:0]      sh_byte,
   output logic            cs_n,
   output logic            busy,
   output logic            err
);
   npw_state_e      state;
   npw_job_t        job_q;
   logic [IDXW-1:0] idx;
   logic            sent;
   logic [1:0]      addr_last;
   logic [1:0]      asel;
   logic [IDXW-1:0] data_last;

   assign busy      = (state != ST_IDLE);
   assign sh_load   = busy && sh_idle && !sent;
   assign buf_idx   = idx;
   assign addr_last = job_q.four ? 2'd3 : 2'd2;
   assign asel      = addr_last - idx[1:0];
   assign data_last = job_q.buffered ? IDXW'(PAGE_BYTES - 1) : '0;

   always_comb begin
      unique case (state)
         ST_OPC:  sh_byte = job_q.opcode;
         ST_ADDR: sh_byte = job_q.addr[{asel, 3'b000} +: 8];
         ST_DATA: sh_byte = job_q.buffered ? buf_byte : job_q.single;
         default: sh_byte = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         job_q <= '0;
         idx   <= '0;
         sent  <= 1'b0;
         cs_n  <= 1'b1;
         err   <= 1'b0;
      end else if (state == ST_IDLE) begin
         if (start) begin
            if (job.buffered && !buf_full) begin
               err <= 1'b1;
            end else begin
               err   <= 1'b0;
               job_q <= job;
               idx   <= '0;
               sent  <= 1'b0;
               cs_n  <= 1'b0;
               state <= ST_OPC;
            end
         end
      end else begin
         if (sh_load) sent <= 1'b1;
         if (sh_done) begin
            sent <= 1'b0;
            unique case (state)
               ST_OPC: begin
                  state <= ST_ADDR;
                  idx   <= '0;
               end
               ST_ADDR: begin
                  if (idx[1:0] == addr_last) begin
                     state <= ST_DATA;
                     idx   <= '0;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (idx == data_last) begin
                     state <= ST_IDLE;
                     cs_n  <= 1'b1;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   p_cs_tracks_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy == !cs_n);
   p_err_only_underfill_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> $past(start && job.buffered && !buf_full && !busy));
   p_no_frame_on_underfill_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && job.buffered && !buf_full) |=> cs_n);
endmodule

// File: rtl/nor_page_writer.sv
module nor_page_writer
   import npw_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int PAGE_BYTES = 128,
   parameter int SCK_HALF   = 2,
   localparam int BPW   = WORD_W / 8,
   localparam int WORDS = PAGE_BYTES / BPW,
   localparam int IDXW  = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              buf_en_req,
   output logic              buf_en_ack,
   input  logic              pd_valid,
   input  logic [WORD_W-1:0] pd_word,
   input  logic [7:0]        tx_opcode,
   input  logic [31:0]       flash_addr,
   input  logic              addr_4byte,
   input  logic [7:0]        single_byte,
   input  logic              wr_start,
   output logic              wr_busy,
   output logic              underfill_err,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi
);
   generate
      if (WORD_W % 8 != 0 || WORD_W < 8) begin : g_bad_word
         $error("WORD_W must be a positive multiple of 8");
      end
      if ((BPW & (BPW - 1)) != 0) begin : g_bad_lanes
         $error("WORD_W/8 must be a power of two");
      end
      if (PAGE_BYTES < 4 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two of at least 4");
      end
      if (PAGE_BYTES % BPW != 0) begin : g_bad_fit
         $error("PAGE_BYTES must hold a whole number of words");
      end
      if (SCK_HALF < 1) begin : g_bad_sck
         $error("SCK_HALF must be at least 1");
      end
   endgenerate

   logic            mode_q;
   logic            buf_clr;
   logic            buf_push;
   logic            buf_full;
   logic [7:0]      buf_byte;
   logic [IDXW-1:0] buf_idx;
   logic            sh_idle;
   logic            sh_done;
   logic            sh_load;
   logic [7:0]      sh_byte;
   npw_job_t        job;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mode_q <= 1'b0;
      else if (!wr_busy) mode_q <= buf_en_req;
   end

   assign buf_en_ack = mode_q;
   assign buf_clr    = !mode_q && buf_en_req && !wr_busy;
   assign buf_push   = pd_valid && mode_q && !wr_busy;

   assign job.opcode   = tx_opcode;
   assign job.addr     = flash_addr;
   assign job.four     = addr_4byte;
   assign job.buffered = mode_q;
   assign job.single   = single_byte;

   npw_word_buf #(.WORD_W(WORD_W), .DEPTH(WORDS)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (buf_clr),
      .push   (buf_push),
      .wdata  (pd_word),
      .rd_idx (buf_idx),
      .rd_byte(buf_byte),
      .full   (buf_full)
   );

   npw_sequencer #(.PAGE_BYTES(PAGE_BYTES)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (wr_start),
      .job     (job),
      .buf_full(buf_full),
      .buf_byte(buf_byte),
      .buf_idx (buf_idx),
      .sh_idle (sh_idle),
      .sh_done (sh_done),
      .sh_load (sh_load),
      .sh_byte (sh_byte),
      .cs_n    (spi_cs_n),
      .busy    (wr_busy),
      .err     (underfill_err)
   );

   npw_bit_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
      .clk  (clk),
      .rst_n(rst_n),
      .load (sh_load),
      .din  (sh_byte),
      .idle (sh_idle),
      .done (sh_done),
      .sck  (spi_sck),
      .mosi (spi_mosi)
   );

   p_mode_frozen_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_q) |-> !$past(wr_busy));
   p_sck_only_framed_r12: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);
endmodule

// File: tb/tb_nor_page_writer.sv
module tb_nor_page_writer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        buf_en_req = 1'b0;
   logic        buf_en_ack;
   logic        pd_valid = 1'b0;
   logic [31:0] pd_word = '0;
   logic [7:0]  tx_opcode = '0;
   logic [31:0] flash_addr = '0;
   logic        addr_4byte = 1'b0;
   logic [7:0]  single_byte = '0;
   logic        wr_start = 1'b0;
   logic        wr_busy;
   logic        underfill_err;
   logic        spi_sck;
   logic        spi_cs_n;
   logic        spi_mosi;

   int          checks = 0;
   int          errors = 0;
   int          cycles = 0;
   bit          finished = 1'b0;
   logic [7:0]  expq [$];
   logic [31:0] page [32];

   always #2 clk = ~clk;

   nor_page_writer dut (
      .clk(clk), .rst_n(rst_n), .buf_en_req(buf_en_req), .buf_en_ack(buf_en_ack),
      .pd_valid(pd_valid), .pd_word(pd_word), .tx_opcode(tx_opcode),
      .flash_addr(flash_addr), .addr_4byte(addr_4byte), .single_byte(single_byte),
      .wr_start(wr_start), .wr_busy(wr_busy), .underfill_err(underfill_err),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=done", cycles);
         finish_run();
      end
   end

   // monitor: collect bytes on the wire and compare with the scoreboard
   int         bitn = 0;
   logic [7:0] shv = '0;
   always @(posedge spi_sck) begin
      shv = {shv[6:0], spi_mosi};
      bitn++;
      if (bitn == 8) begin
         bitn = 0;
         if (expq.size() == 0) begin
            check(1'b0, "R10 unexpected byte on wire", 64'(shv), 64'hx);
         end else begin
            logic [7:0] e;
            e = expq.pop_front();
            check(shv == e, "R6/R8 wire byte (R12 msb first)", 64'(shv), 64'(e));
         end
      end
   end

   always @(posedge spi_cs_n) begin
      if (rst_n)
         check(expq.size() == 0 && bitn == 0, "R8 frame length at cs rise",
               64'(expq.size()), 64'd0);
   end

   logic prev_sck = 1'b0, prev_mosi = 1'b0;
   always @(negedge clk) begin
      if (rst_n && spi_sck && prev_sck)
         check(spi_mosi == prev_mosi, "R12 mosi stable while sck high",
               64'(spi_mosi), 64'(prev_mosi));
      if (rst_n && spi_cs_n)
         check(!spi_sck, "R12 sck low when idle", 64'(spi_sck), 64'd0);
      prev_sck  = spi_sck;
      prev_mosi = spi_mosi;
   end

   // driver helpers
   task automatic expect_header(input logic [7:0] opc, input logic [31:0] a, input bit four);
      expq.push_back(opc);
      if (four) expq.push_back(a[31:24]);
      expq.push_back(a[23:16]);
      expq.push_back(a[15:8]);
      expq.push_back(a[7:0]);
   endtask

   task automatic expect_page();
      for (int i = 0; i < 128; i++) expq.push_back(page[i/4][(i%4)*8 +: 8]);
   endtask

   task automatic push_word(input logic [31:0] w);
      @(negedge clk);
      pd_valid = 1'b1;
      pd_word  = w;
      @(negedge clk);
      pd_valid = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      wr_start = 1'b1;
      @(negedge clk);
      wr_start = 1'b0;
   endtask

   task automatic wait_idle(input string tag);
      int n = 0;
      while (wr_busy && n < 20000) begin
         @(negedge clk);
         n++;
      end
      check(!wr_busy, tag, 64'(wr_busy), 64'd0);
      repeat (4) @(negedge clk);
   endtask

   task automatic set_mode(input bit m);
      int n = 0;
      @(negedge clk);
      buf_en_req = m;
      @(negedge clk);
      while (buf_en_ack != m && n < 10) begin
         @(negedge clk);
         n++;
      end
      check(buf_en_ack == m, "R2 mode read-back follows request", 64'(buf_en_ack), 64'(m));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(spi_cs_n == 1'b1, "R1 cs_n reset", 64'(spi_cs_n), 64'd1);
      check(spi_sck == 1'b0, "R1 sck reset", 64'(spi_sck), 64'd0);
      check(wr_busy == 1'b0, "R1 busy reset", 64'(wr_busy), 64'd0);
      check(buf_en_ack == 1'b0, "R1 ack reset", 64'(buf_en_ack), 64'd0);
      check(underfill_err == 1'b0, "R1 err reset", 64'(underfill_err), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R9 + R6: unbuffered single-byte program, 3-byte address
      tx_opcode = 8'h02; flash_addr = 32'hFF12_3456; addr_4byte = 1'b0;
      single_byte = 8'hA5;
      expect_header(8'h02, 32'hFF12_3456, 1'b0);
      expq.push_back(8'hA5);
      pulse_start();
      check(wr_busy == 1'b1, "R10 busy after start", 64'(wr_busy), 64'd1);
      wait_idle("R9 single-byte frame ends");

      // R2/R3/R4/R7/R8: buffered page, 4-byte address
      set_mode(1'b1);
      for (int k = 0; k < 32; k++) begin
         page[k] = {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)} ^ 32'h5A00_C300;
         push_word(page[k]);
      end
      push_word(32'hFFFF_FFFF); // R4 overflow push must be ignored
      tx_opcode = 8'h12; flash_addr = 32'hDEAD_BEEF; addr_4byte = 1'b1;
      expect_header(8'h12, 32'hDEAD_BEEF, 1'b1);
      expect_page();
      pulse_start();
      // R10: second start while busy is ignored
      repeat (50) @(negedge clk);
      wr_start = 1'b1;
      @(negedge clk);
      wr_start = 1'b0;
      // R2: drop request mid-transfer, read-back must hold
      buf_en_req = 1'b0;
      repeat (20) @(negedge clk);
      check(buf_en_ack == 1'b1, "R2 mode held during transfer", 64'(buf_en_ack), 64'd1);
      check(wr_busy == 1'b1, "R10 still busy mid-frame", 64'(wr_busy), 64'd1);
      while (wr_busy) @(negedge clk);
      @(negedge clk);
      check(buf_en_ack == 1'b0, "R2 mode switches after transfer", 64'(buf_en_ack), 64'd0);
      repeat (300) @(negedge clk);
      check(spi_cs_n == 1'b1 && !wr_busy, "R10 no extra frame from ignored start",
            64'(spi_cs_n), 64'd1);

      // R5/R11: re-enable, partial fill, refused start
      set_mode(1'b1);
      for (int k = 0; k < 10; k++) begin
         page[k] = 32'h1000_0000 + 32'(k * 32'h0103_0507);
         push_word(page[k]);
      end
      tx_opcode = 8'h02; flash_addr = 32'h00AB_CDEF; addr_4byte = 1'b0;
      pulse_start();
      check(underfill_err == 1'b1, "R11 underfill flag set", 64'(underfill_err), 64'd1);
      check(wr_busy == 1'b0, "R11 no busy on refused start", 64'(wr_busy), 64'd0);
      check(spi_cs_n == 1'b1, "R11 cs stays high on refused start", 64'(spi_cs_n), 64'd1);
      for (int k = 10; k < 32; k++) begin
         page[k] = 32'h1000_0000 + 32'(k * 32'h0103_0507);
         push_word(page[k]);
      end
      expect_header(8'h02, 32'h00AB_CDEF, 1'b0);
      expect_page();
      pulse_start();
      check(underfill_err == 1'b0, "R11 flag cleared by accepted start", 64'(underfill_err), 64'd0);
      wait_idle("R5 refilled page frame ends");
      check(expq.size() == 0, "R5 all refilled bytes sent", 64'(expq.size()), 64'd0);

      finish_run();
   end
endmodule